// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block sequences programmed-I/O transfers on one ATA/IDE channel. A host raises a request that carries the direction (read or write), the target device (master or slave), the access width (8-bit or 16-bit), the task-file address, the chip-select choice and, for writes, the data word. The block then runs three phases, each counted in bus clocks: address setup, strobe active and recovery. It returns a one-clock acknowledge when recovery ends. For a read it captures the data bus on the last clock of the active phase.

Each phase length comes from a programmable 4-bit count that holds the wanted number of clocks minus one. A zero field therefore still gives one clock, and the longest phase is sixteen clocks. Each device has its own timing byte for 16-bit reads, for 16-bit writes and for 8-bit accesses. The active count sits in the upper nibble of a timing byte and the recovery count in the lower nibble. One shared setup byte holds a setup count for each device. Software loads all of these through a dword-wide write port with byte enables. The block samples the selected counts when it accepts a request, so a register write made during a transfer only takes effect from the next transfer.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset every timing and setup byte holds 0xFF, so each phase lasts 16 clocks. Both strobes read 1, chip selects read all ones, `dd_oe` is 0 and `ack` is 0.
- R2: An accepted transfer runs setup for S+1 clocks, then active for A+1 clocks, then recovery for R+1 clocks, where S, A and R are the selected 4-bit fields.
- R3: During a read only `dior_n` goes low, during a write only `diow_n` goes low, and only in the active phase. The two strobes are never low together.
- R4: In a timing byte, bits [7:4] are the active count and bits [3:0] are the recovery count.
- R5: The timing byte is chosen by device, direction and width. Byte addresses: master 16-bit read 0x4C, master 16-bit write 0x4D, slave 16-bit read 0x4E, slave 16-bit write 0x4F, master 8-bit 0x50, slave 8-bit 0x51. An 8-bit access uses the same byte for reads and writes.
- R6: The setup byte is byte lane 0 of the dword at 0x48. Bits [3:0] are the master's setup count and bits [7:4] are the slave's.
- R7: A configuration write changes only the bytes whose lane enable `cfg_be[l]` is set and whose byte address (`cfg_addr[7:2]` joined with lane l) matches a register. Other lanes and unmapped addresses leave every count unchanged.
- R8: From the first setup clock to the last recovery clock, `ata_addr` equals the request address and `ata_cs_n` equals the inverted request chip select. While idle, `ata_cs_n` is all ones.
- R9: On a write, `dd_oe` is 1 and `dd_out` carries the request data from the first setup clock through the last active clock. `dd_oe` is 0 in recovery, in idle and during reads.
- R10: On a read, `rdata` takes the value `dd_in` has on the last active clock and keeps it until the next read capture.
- R11: `ack` is high for exactly one clock, in the clock that follows the last recovery clock. A request is accepted only while idle with `ack` low, so a requester that drops `req` on `ack` starts no second transfer.
- R12: The counts are sampled at acceptance. A configuration write during a transfer does not change that transfer's phase lengths, but it does apply to the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address, dword aligned |
| cfg_be | input | 4 | Byte-lane enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| req | input | 1 | Transfer request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dev | input | 1 | 0 = master, 1 = slave |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | 3 | Task-file register address |
| req_cs | input | 2 | Chip selects to assert, active high |
| req_wdata | input | 16 | Write data |
| dd_in | input | 16 | Data bus from the drive |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| ata_addr | output | 3 | Drive address lines |
| ata_cs_n | output | 2 | Drive chip selects, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus to the drive |
| dd_oe | output | 1 | Data bus drive enable |

## Verification
The bench programs all-zero counts, all-one counts and distinct per-register values. An off-by-one in the minus-one encoding would then show up as phases one clock short or long, and a swapped nibble would exchange the active and recovery lengths. It runs every device, direction and width combination, so a selection mux wired to the wrong byte yields a length that belongs to another register. A partial byte-enable write and a write to an unmapped address catch decode that changes neighbouring bytes or ignores lane enables. A write issued during a running transfer catches a design that reads the registers live instead of sampling them at acceptance. On reads, the bench changes `dd_in` on every clock, so a capture one clock early or late returns the wrong value.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } pio_phase_e;

   // index of a per-device timing byte
   localparam int KIND_RD16 = 0;
   localparam int KIND_WR16 = 1;
   localparam int KIND_NARROW = 2;
   localparam int NUM_KIND = 3;

   function automatic int unsigned pick_kind(input logic wr, input logic wide);
      if (!wide) return KIND_NARROW;
      return wr ? KIND_WR16 : KIND_RD16;
   endfunction

   // byte address of timing byte (dev, kind)
   function automatic int unsigned tim_offset(input int unsigned base16, input int unsigned base8,
                                              input int unsigned dev, input int unsigned kind);
      if (kind == KIND_NARROW) return base8 + dev;
      return base16 + 2 * dev + kind;
   endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
   import pio_pkg::*;
#(
   parameter int CFG_AW    = 8,
   parameter int CNT_W     = 4,
   parameter int SETUP_OFS = 'h48,
   parameter int T16_BASE  = 'h4C,
   parameter int T8_BASE   = 'h50
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cfg_we,
   input  logic [CFG_AW-1:0]                    cfg_addr,
   input  logic [3:0]                           cfg_be,
   input  logic [31:0]                          cfg_wdata,
   output logic [2*CNT_W-1:0]                   setup_byte,
   output logic [1:0][NUM_KIND-1:0][2*CNT_W-1:0] tim
);
   localparam int BYTE_W = 2 * CNT_W;

   // byte address seen on lane l
   function automatic logic [CFG_AW-1:0] lane_addr(input logic [CFG_AW-1:0] a, input int l);
      return {a[CFG_AW-1:2], 2'(l)};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_byte <= '1;
      end else if (cfg_we) begin
         for (int l = 0; l < 4; l++) begin
            if (cfg_be[l] && lane_addr(cfg_addr, l) == CFG_AW'(SETUP_OFS))
               setup_byte <= cfg_wdata[8*l +: BYTE_W];
         end
      end
   end

   for (genvar d = 0; d < 2; d++) begin : g_dev
      for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
         localparam int OFS = int'(tim_offset(T16_BASE, T8_BASE, d, k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tim[d][k] <= '1;
            end else if (cfg_we) begin
               for (int l = 0; l < 4; l++) begin
                  if (cfg_be[l] && lane_addr(cfg_addr, l) == CFG_AW'(OFS))
                     tim[d][k] <= cfg_wdata[8*l +: BYTE_W];
               end
            end
         end
      end
   end

endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
   import pio_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic [2*CNT_W-1:0]                    setup_byte,
   input  logic [1:0][NUM_KIND-1:0][2*CNT_W-1:0] tim,
   input  logic                                  wr,
   input  logic                                  wide,
   input  logic                                  dev,
   output logic [CNT_W-1:0]                      setup_cnt,
   output logic [CNT_W-1:0]                      act_cnt,
   output logic [CNT_W-1:0]                      rec_cnt
);
   logic [2*CNT_W-1:0] sel_byte;

   always_comb begin
      sel_byte  = tim[dev][pick_kind(wr, wide)];
      act_cnt   = sel_byte[2*CNT_W-1:CNT_W];
      rec_cnt   = sel_byte[CNT_W-1:0];
      setup_cnt = dev ? setup_byte[2*CNT_W-1:CNT_W] : setup_byte[CNT_W-1:0];
   end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
   import pio_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CNT_W-1:0] setup_cnt,
   input  logic [CNT_W-1:0] act_cnt,
   input  logic [CNT_W-1:0] rec_cnt,
   output logic             accept,
   output pio_phase_e       phase,
   output logic             act_last,
   output logic             done
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_q;
   logic [CNT_W-1:0] rec_q;
   logic             cnt_zero;

   assign cnt_zero = (cnt == '0);
   assign accept   = (phase == PH_IDLE) && req && !done;
   assign act_last = (phase == PH_ACTIVE) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         act_q <= '0;
         rec_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (accept) begin
                  phase <= PH_SETUP;
                  cnt   <= setup_cnt;
                  act_q <= act_cnt;
                  rec_q <= rec_cnt;
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  phase <= PH_ACTIVE;
                  cnt   <= act_q;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_ACTIVE: begin
               if (cnt_zero) begin
                  phase <= PH_RECOV;
                  cnt   <= rec_q;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_RECOV: begin
               if (cnt_zero) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
   import pio_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int CS_W      = 2,
   parameter int CFG_AW    = 8,
   parameter int CNT_W     = 4,
   parameter int SETUP_OFS = 'h48,
   parameter int T16_BASE  = 'h4C,
   parameter int T8_BASE   = 'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   input  logic              req,
   input  logic              req_wr,
   input  logic              req_dev,
   input  logic              req_wide,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dd_in,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] ata_addr,
   output logic [CS_W-1:0]   ata_cs_n,
   output logic              dior_n,
   output logic              diow_n,
   output logic [DATA_W-1:0] dd_out,
   output logic              dd_oe
);
   localparam int BYTE_W = 2 * CNT_W;

   // elaboration checks
   if (BYTE_W != 8) begin : g_bad_cnt
      $error("CNT_W must be 4: two counts share one byte");
   end
   if (CFG_AW < 3) begin : g_bad_aw
      $error("CFG_AW too small for dword decode");
   end
   if (SETUP_OFS % 4 != 0) begin : g_bad_setup
      $error("SETUP_OFS must be dword aligned");
   end
   if (T16_BASE >= (1 << CFG_AW) - 3 || T8_BASE >= (1 << CFG_AW) - 1) begin : g_bad_ofs
      $error("timing offsets exceed configuration space");
   end

   logic [BYTE_W-1:0]                    setup_byte;
   logic [1:0][NUM_KIND-1:0][BYTE_W-1:0] tim;
   logic [CNT_W-1:0]                     setup_cnt, act_cnt, rec_cnt;
   logic                                 accept, act_last, done;
   pio_phase_e                           phase;

   logic                                 wr_q;
   logic [ADDR_W-1:0]                    addr_q;
   logic [CS_W-1:0]                      cs_q;
   logic [DATA_W-1:0]                    wdata_q;
   logic [DATA_W-1:0]                    rdata_q;

   pio_timing_regs #(
      .CFG_AW   (CFG_AW),
      .CNT_W    (CNT_W),
      .SETUP_OFS(SETUP_OFS),
      .T16_BASE (T16_BASE),
      .T8_BASE  (T8_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .setup_byte(setup_byte),
      .tim       (tim)
   );

   pio_timing_sel #(.CNT_W(CNT_W)) u_sel (
      .setup_byte(setup_byte),
      .tim       (tim),
      .wr        (req_wr),
      .wide      (req_wide),
      .dev       (req_dev),
      .setup_cnt (setup_cnt),
      .act_cnt   (act_cnt),
      .rec_cnt   (rec_cnt)
   );

   pio_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .setup_cnt(setup_cnt),
      .act_cnt  (act_cnt),
      .rec_cnt  (rec_cnt),
      .accept   (accept),
      .phase    (phase),
      .act_last (act_last),
      .done     (done)
   );

   // request context held for the whole transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         cs_q    <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         wr_q    <= req_wr;
         addr_q  <= req_addr;
         cs_q    <= req_cs;
         wdata_q <= req_wdata;
      end
   end

   // read capture on last active clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (act_last && !wr_q)
         rdata_q <= dd_in;
   end

   always_comb begin
      ack      = done;
      rdata    = rdata_q;
      ata_addr = addr_q;
      ata_cs_n = (phase == PH_IDLE) ? '1 : ~cs_q;
      dior_n   = !((phase == PH_ACTIVE) && !wr_q);
      diow_n   = !((phase == PH_ACTIVE) && wr_q);
      dd_oe    = wr_q && ((phase == PH_SETUP) || (phase == PH_ACTIVE));
      dd_out   = wdata_q;
   end

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter int CS_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic [DATA_W-1:0] rdata,
   input logic [ADDR_W-1:0] ata_addr,
   input logic [CS_W-1:0]   ata_cs_n,
   input logic              dior_n,
   input logic              diow_n,
   input logic              dd_oe
);
   logic sel_on;
   assign sel_on = (ata_cs_n != '1);

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dior_n && !diow_n));

   // R2
   setup_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dior_n) |-> $past(sel_on) && $past(dior_n));

   // R2
   setup_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(diow_n) |-> $past(sel_on) && $past(dd_oe));

   // R11
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R11
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !sel_on && dior_n && diow_n && !dd_oe);

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_on && $past(sel_on)) |-> $stable(ata_addr) && $stable(ata_cs_n));

   // R9
   write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !diow_n |-> dd_oe);

   // R9
   read_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dior_n |-> !dd_oe);

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(dior_n) |-> $stable(rdata));

endmodule

bind pio_strobe_gen pio_strobe_gen_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W),
   .CS_W  (CS_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ack     (ack),
   .rdata   (rdata),
   .ata_addr(ata_addr),
   .ata_cs_n(ata_cs_n),
   .dior_n  (dior_n),
   .diow_n  (diow_n),
   .dd_oe   (dd_oe)
);

// File: tb/pio_strobe_gen_tb_top.sv
module pio_strobe_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [7:0]  cfg_addr;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic        req, req_wr, req_dev, req_wide;
   logic [2:0]  req_addr;
   logic [1:0]  req_cs;
   logic [15:0] req_wdata;
   logic [15:0] dd_in;
   logic        ack;
   logic [15:0] rdata;
   logic [2:0]  ata_addr;
   logic [1:0]  ata_cs_n;
   logic        dior_n, diow_n;
   logic [15:0] dd_out;
   logic        dd_oe;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] sh_setup;
   logic [7:0] sh_tim [2][3];

   always #5 clk = ~clk;

   pio_strobe_gen dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .req(req), .req_wr(req_wr), .req_dev(req_dev), .req_wide(req_wide),
      .req_addr(req_addr), .req_cs(req_cs), .req_wdata(req_wdata), .dd_in(dd_in),
      .ack(ack), .rdata(rdata), .ata_addr(ata_addr), .ata_cs_n(ata_cs_n),
      .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   // register model from the address list of R5, R6 and R7
   function automatic void sh_apply(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      for (int l = 0; l < 4; l++) begin
         if (be[l]) begin
            logic [7:0] ba;
            logic [7:0] v;
            ba = {a[7:2], 2'(l)};
            v  = d[8*l +: 8];
            case (ba)
               8'h48: sh_setup = v;
               8'h4C: sh_tim[0][0] = v;
               8'h4D: sh_tim[0][1] = v;
               8'h4E: sh_tim[1][0] = v;
               8'h4F: sh_tim[1][1] = v;
               8'h50: sh_tim[0][2] = v;
               8'h51: sh_tim[1][2] = v;
               default: ;
            endcase
         end
      end
   endfunction

   task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
      sh_apply(a, be, d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic access(input bit wr, input bit dev, input bit wide, input logic [2:0] ad,
                         input logic [1:0] cs, input logic [15:0] wd, input bit mid,
                         input string tag);
      logic [7:0] tb;
      int es, ea, er;
      int s, a, r, i;
      bit ok_strb, ok_hold, ok_dd, got_ack, low;
      logic [7:0] rtag;
      tb = wide ? (wr ? sh_tim[dev][1] : sh_tim[dev][0]) : sh_tim[dev][2];
      es = int'(dev ? sh_setup[7:4] : sh_setup[3:0]) + 1;
      ea = int'(tb[7:4]) + 1;
      er = int'(tb[3:0]) + 1;
      s = 0; a = 0; r = 0; i = 0;
      ok_strb = 1; ok_hold = 1; ok_dd = 1; got_ack = 0;
      rtag = 8'($urandom);
      @(negedge clk);
      req = 1'b1; req_wr = wr; req_dev = dev; req_wide = wide;
      req_addr = ad; req_cs = cs; req_wdata = wd;
      while (!got_ack && i < 200) begin
         @(negedge clk);
         i++;
         cfg_we = 1'b0;
         if (ack) begin
            got_ack = 1;
            req = 1'b0;
         end else begin
            if (ata_cs_n != ~cs || ata_addr != ad) ok_hold = 0;
            if (wr ? !dior_n : !diow_n) ok_strb = 0;
            low = wr ? !diow_n : !dior_n;
            if (low) a++;
            else if (a == 0) s++;
            else r++;
            if (wr) begin
               if (a > 0 && !low) begin
                  if (dd_oe) ok_dd = 0;
               end else if (!dd_oe || dd_out != wd) ok_dd = 0;
            end else if (dd_oe) ok_dd = 0;
            dd_in = {rtag, 8'(a)};
            if (mid && i == 2) begin
               cfg_we = 1'b1; cfg_addr = 8'h4C; cfg_be = 4'hF; cfg_wdata = 32'h0;
               sh_apply(8'h4C, 4'hF, 32'h0);
            end
         end
      end
      chk(got_ack, {"R11 ack seen ", tag}, got_ack, 1);
      chk(s == es, {"R2 R6 setup clocks ", tag}, s, es);
      chk(a == ea, {"R2 R4 R5 active clocks ", tag}, a, ea);
      chk(r == er, {"R2 R4 R5 recovery clocks ", tag}, r, er);
      chk(ok_strb, {"R3 wrong strobe ", tag}, ok_strb, 1);
      chk(ok_hold, {"R8 address/select hold ", tag}, ok_hold, 1);
      chk(ok_dd, {"R9 write data window ", tag}, ok_dd, 1);
      if (!wr) chk(rdata == {rtag, 8'(ea)}, {"R10 read capture ", tag}, rdata, {rtag, 8'(ea)});
      @(negedge clk);
      chk(!ack && ata_cs_n == 2'b11, {"R11 ack width ", tag}, {ack, ata_cs_n}, 3'b011);
      @(negedge clk);
      chk(ata_cs_n == 2'b11 && dior_n && diow_n, {"R11 no restart ", tag},
          {ata_cs_n, dior_n, diow_n}, 4'hF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd61803));
      rst_n = 1'b0;
      cfg_we = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
      req = 0; req_wr = 0; req_dev = 0; req_wide = 0; req_addr = 0; req_cs = 0;
      req_wdata = 0; dd_in = 0;
      sh_setup = 8'hFF;
      for (int d = 0; d < 2; d++)
         for (int k = 0; k < 3; k++) sh_tim[d][k] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 idle outputs after reset
      chk(dior_n && diow_n && ata_cs_n == 2'b11 && !ack && !dd_oe, "R1 reset outputs",
          {dior_n, diow_n, ata_cs_n, ack, dd_oe}, 6'b111100);
      // R1 default counts give sixteen clocks per phase
      access(0, 0, 1, 3'd7, 2'b01, 16'h0, 0, "R1 defaults read");
      access(1, 1, 0, 3'd1, 2'b10, 16'hBEEF, 0, "R1 defaults write");

      // all-zero counts: one clock per phase
      cfg_write(8'h48, 4'h1, 32'h0);
      cfg_write(8'h4C, 4'hF, 32'h0);
      cfg_write(8'h50, 4'h3, 32'h0);
      access(1, 1, 0, 3'd2, 2'b01, 16'h1234, 0, "R2 minimum write");
      access(0, 0, 1, 3'd0, 2'b11, 16'h0, 0, "R2 minimum read");

      // distinct value per register: R5 R6
      cfg_write(8'h48, 4'h1, 32'h0000_0073);
      cfg_write(8'h4C, 4'hF, 32'h4F3E_2D1C);
      cfg_write(8'h50, 4'h3, 32'h0000_6A59);
      access(0, 0, 1, 3'd1, 2'b01, 16'h0, 0, "R5 master rd16");
      access(1, 0, 1, 3'd2, 2'b01, 16'hA5A5, 0, "R5 master wr16");
      access(0, 1, 1, 3'd3, 2'b10, 16'h0, 0, "R5 slave rd16");
      access(1, 1, 1, 3'd4, 2'b10, 16'h5A5A, 0, "R5 slave wr16");
      access(0, 0, 0, 3'd5, 2'b01, 16'h0, 0, "R5 master narrow rd");
      access(1, 1, 0, 3'd6, 2'b10, 16'h00C3, 0, "R5 slave narrow wr");

      // R7 partial lanes and unmapped address
      cfg_write(8'h4C, 4'b0100, 32'hFFA7_FFFF);
      cfg_write(8'h54, 4'hF, 32'hFFFF_FFFF);
      cfg_write(8'h48, 4'hE, 32'hFFFF_FFFF);
      access(0, 0, 1, 3'd1, 2'b01, 16'h0, 0, "R7 untouched neighbour");
      access(0, 1, 1, 3'd1, 2'b10, 16'h0, 0, "R7 enabled lane");

      // R12 write during a transfer
      access(0, 0, 1, 3'd2, 2'b01, 16'h0, 1, "R12 mid-transfer write");
      access(0, 0, 1, 3'd2, 2'b01, 16'h0, 0, "R12 next transfer");

      // constrained random mix
      for (int n = 0; n < 40; n++) begin
         logic [7:0] ra;
         case ($urandom_range(2, 0))
            0: ra = 8'h48;
            1: ra = 8'h4C;
            default: ra = 8'h50;
         endcase
         cfg_write(ra, 4'($urandom), $urandom);
         access(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
                2'($urandom_range(3, 1)), 16'($urandom), 1'($urandom_range(3, 0) == 0),
                "R2 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule